// File: doc/BRIEF.md
# Serial Command Frame Receiver with CRC7 Check

This block listens to the host-to-card command line one bit per clock edge and gathers fixed 48-bit command frames. A frame opens with a 0 start bit. After it come a direction bit, a 6-bit command index, a 32-bit argument, a 7-bit checksum and a closing 1. The frame is sent most significant bit first. While the line idles at 1 the receiver waits. The first sampled 0 opens a frame.

Once the closing bit has been sampled, the receiver checks three things: the direction bit, the end bit and the checksum. When all three hold, the index and argument are offered on a valid/ready output. When any of them fails, a one-cycle error strobe is raised instead.

The checksum logic is a stand-alone serial LFSR module, `crc7_lfsr`. It divides by x^7 + x^3 + 1, and the same module can build checksums for outgoing responses and for 128-bit register images.

The output follows valid/ready rules. `cmd_valid` rises in the cycle after the end bit is sampled and then holds, with its index and argument frozen, until a cycle in which `cmd_ready` is high. The serial line cannot be stalled. For that reason, while a result is still unaccepted, the receiver does not open a new frame, and any frame sent during that time is lost.

Top module: `cmd_frame_rx`

## Requirements
- R1: After reset, `cmd_valid` and `cmd_crc_err` are both 0.
- R2: While idle, a sampled 1 on `cmd_line` starts nothing. A sampled 0 starts a frame when no result is pending or when `cmd_ready` is high in that cycle.
- R3: For a correct frame, in the cycle after the end bit (frame bit 0) is sampled, `cmd_valid` is 1, `cmd_index` equals frame bits 45..40 and `cmd_arg` equals frame bits 39..8.
- R4: If frame bits 7..1 differ from the CRC7 of frame bits 47..8, `cmd_crc_err` is 1 for exactly one cycle, in the cycle after the end bit, and `cmd_valid` stays 0.
- R5: If frame bit 46 (the direction bit) is 0, the frame is rejected with the error strobe and no valid.
- R6: If frame bit 0 (the end bit) is 0, the frame is rejected with the error strobe and no valid.
- R7: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_index` and `cmd_arg` hold. A frame sent during that time produces neither a valid nor an error.
- R8: With `cmd_ready` held high, two frames sent with no idle bit between them are both delivered.
- R9: `crc7_lfsr` uses generator x^7+x^3+1, starting from zero, and fed MSB first. It yields the remainder of M(x)*x^7. For a 128-bit register image fed bits 127..8, this is the value placed in bits 7..1. For example, command 0 with argument 0 gives 0x4A, and command 17 with argument 0 gives 0x2A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one line bit is sampled per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_line | input | 1 | Serial command line from the host, idles high |
| cmd_ready | input | 1 | Consumer accepts the offered command |
| cmd_valid | output | 1 | A checked command is offered |
| cmd_index | output | 6 | Command index of the offered command |
| cmd_arg | output | 32 | Argument of the offered command |
| cmd_crc_err | output | 1 | One-cycle strobe for a rejected frame |

## Verification
The hardest situation to reach is a frame that arrives while an earlier result is still unaccepted. That frame must vanish without disturbing the held output. The bench reaches it by holding `cmd_ready` low across a complete second frame, keeping the line high afterwards, and only then raising `cmd_ready`. The other hard case is a back-to-back pair: there, the start bit of the second frame lands in the same cycle in which the first result is offered, and the bench drives the two frames as one continuous 96-bit stream.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;
  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BODY = 1'b1
  } rx_state_e;
endpackage

// File: rtl/crc7_lfsr.sv
module crc7_lfsr #(
  parameter int CRC_W = 7,
  parameter logic [CRC_W-1:0] POLY = 7'h09
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  logic             fb;
  logic [CRC_W-1:0] nxt;

  always_comb begin
    fb  = din ^ crc[CRC_W-1];
    nxt = {crc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= nxt;
  end

  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == '0));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(crc));
endmodule

// File: rtl/cmd_deframer.sv
module cmd_deframer
  import cmdrx_pkg::*;
#(
  parameter int FRAME_W = 48,
  parameter int IDX_W   = 6,
  parameter int ARG_W   = 32,
  parameter int CRC_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic             accept_i,
  input  logic [CRC_W-1:0] crc_val_i,
  output logic             crc_clr_o,
  output logic             crc_en_o,
  output logic             crc_bit_o,
  output logic             fin_ok_o,
  output logic             fin_bad_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [ARG_W-1:0] arg_o
);
  localparam int BODY_W = FRAME_W - 2;
  localparam int CNT_W  = $clog2(FRAME_W);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [BODY_W-1:0] sr;
  logic              last, good;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      cnt   <= '0;
      sr    <= '0;
    end else if (state == RX_IDLE) begin
      if (accept_i && !line_i) begin
        state <= RX_BODY;
        cnt   <= CNT_W'(FRAME_W - 2);
      end
    end else if (cnt != '0) begin
      sr  <= {sr[BODY_W-2:0], line_i};
      cnt <= cnt - 1'b1;
    end else begin
      state <= RX_IDLE;
    end
  end

  always_comb begin
    crc_clr_o = (state == RX_IDLE);
    crc_en_o  = (state == RX_BODY) && (cnt >= CNT_W'(CRC_W + 1));
    crc_bit_o = line_i;
    last      = (state == RX_BODY) && (cnt == '0);
    good      = sr[BODY_W-1] && line_i && (sr[CRC_W-1:0] == crc_val_i);
    fin_ok_o  = last && good;
    fin_bad_o = last && !good;
    idx_o     = sr[BODY_W-2 -: IDX_W];
    arg_o     = sr[CRC_W +: ARG_W];
  end

  // R2
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_IDLE && accept_i && !line_i) |=> (state == RX_BODY));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_IDLE && (line_i || !accept_i)) |=> (state == RX_IDLE));
endmodule

// File: rtl/cmd_out_stage.sv
module cmd_out_stage #(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fin_ok,
  input  logic             fin_bad,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [ARG_W-1:0] arg_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [ARG_W-1:0] arg_o,
  output logic             err_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
      arg_o   <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= fin_bad;
      if (fin_ok) begin
        valid_o <= 1'b1;
        idx_o   <= idx_i;
        arg_o   <= arg_i;
      end else if (ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end

  // R4
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && err_o));
  // R4
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(idx_o) && $stable(arg_o)));
endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx #(
  parameter int FRAME_W = 48,
  parameter int IDX_W   = 6,
  parameter int ARG_W   = 32,
  parameter int CRC_W   = 7,
  parameter logic [CRC_W-1:0] CRC_POLY = 7'h09
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_line,
  input  logic             cmd_ready,
  output logic             cmd_valid,
  output logic [IDX_W-1:0] cmd_index,
  output logic [ARG_W-1:0] cmd_arg,
  output logic             cmd_crc_err
);
  logic             accept, crc_clr, crc_en, crc_bit, fin_ok, fin_bad;
  logic [CRC_W-1:0] crc_val;
  logic [IDX_W-1:0] idx_w;
  logic [ARG_W-1:0] arg_w;

  assign accept = !cmd_valid || cmd_ready;

  cmd_deframer #(
    .FRAME_W(FRAME_W), .IDX_W(IDX_W), .ARG_W(ARG_W), .CRC_W(CRC_W)
  ) u_deframer (
    .clk(clk), .rst_n(rst_n), .line_i(cmd_line), .accept_i(accept),
    .crc_val_i(crc_val), .crc_clr_o(crc_clr), .crc_en_o(crc_en),
    .crc_bit_o(crc_bit), .fin_ok_o(fin_ok), .fin_bad_o(fin_bad),
    .idx_o(idx_w), .arg_o(arg_w)
  );

  crc7_lfsr #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
    .din(crc_bit), .crc(crc_val)
  );

  cmd_out_stage #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_out (
    .clk(clk), .rst_n(rst_n), .fin_ok(fin_ok), .fin_bad(fin_bad),
    .idx_i(idx_w), .arg_i(arg_w), .ready_i(cmd_ready),
    .valid_o(cmd_valid), .idx_o(cmd_index), .arg_o(cmd_arg),
    .err_o(cmd_crc_err)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!cmd_valid && !cmd_crc_err));
endmodule

// File: tb/test_cmd_frame_rx.sv
module test_cmd_frame_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_line = 1'b1;
  logic        cmd_ready = 1'b1;
  logic        cmd_valid, cmd_crc_err;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_arg;
  logic        e_clr = 1'b1, e_en = 1'b0, e_din = 1'b0;
  logic [6:0]  e_crc;

  int total = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cmd_frame_rx i_cmd_frame_rx (
    .clk(clk), .rst_n(rst_n), .cmd_line(cmd_line), .cmd_ready(cmd_ready),
    .cmd_valid(cmd_valid), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
    .cmd_crc_err(cmd_crc_err)
  );

  crc7_lfsr i_crc (
    .clk(clk), .rst_n(rst_n), .clr(e_clr), .en(e_en), .din(e_din), .crc(e_crc)
  );

  function automatic logic [6:0] crc_of(logic [119:0] m, int n);
    logic [6:0] r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic t = m[i] ^ r[6];
      r = {r[5:0], 1'b0};
      if (t) r = r ^ 7'h09;
    end
    return r;
  endfunction

  // kind: 0 good, 1 bad crc, 2 bad direction, 3 bad end
  function automatic logic [47:0] mk(logic [5:0] idx, logic [31:0] arg, int kind);
    logic [39:0] head = {1'b0, (kind == 2) ? 1'b0 : 1'b1, idx, arg};
    logic [6:0]  c = crc_of({80'd0, head}, 40);
    if (kind == 1) c = c ^ 7'h01;
    return {head, c, (kind == 3) ? 1'b0 : 1'b1};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  task automatic send_bits(logic [47:0] f);
    for (int i = 47; i >= 0; i--) begin
      @(negedge clk) cmd_line = f[i];
    end
  endtask

  task automatic frame_check(logic [5:0] idx, logic [31:0] arg, int kind);
    send_bits(mk(idx, arg, kind));
    @(negedge clk) cmd_line = 1'b1;
    if (kind == 0) begin
      chk("R3 valid", cmd_valid, 1);
      chk("R3 index", cmd_index, idx);
      chk("R3 arg", cmd_arg, arg);
      chk("R3 no err", cmd_crc_err, 0);
    end else begin
      chk(kind == 1 ? "R4 err" : kind == 2 ? "R5 err" : "R6 err", cmd_crc_err, 1);
      chk(kind == 1 ? "R4 no valid" : kind == 2 ? "R5 no valid" : "R6 no valid", cmd_valid, 0);
      @(negedge clk);
      chk("R4 strobe single", cmd_crc_err, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 valid", cmd_valid, 0);
    chk("R1 err", cmd_crc_err, 0);

    // R2: idle line high, nothing happens
    repeat (30) begin
      @(negedge clk);
      chk("R2 idle", {cmd_valid, cmd_crc_err}, 0);
    end

    // R9: known checksums
    chk("R9 cmd0", crc_of({80'd0, 40'h40_0000_0000}, 40), 7'h4A);
    chk("R9 cmd17", crc_of({80'd0, 40'h51_0000_0000}, 40), 7'h2A);

    // R9: engine over register images
    for (int k = 0; k < 2; k++) begin
      logic [119:0] img = (k == 0) ? '0 :
        {$urandom, $urandom, $urandom, $urandom_range(255, 0)[23:0]};
      @(negedge clk) e_clr = 1'b1;
      @(negedge clk) e_clr = 1'b0;
      for (int i = 119; i >= 0; i--) begin
        e_en = 1'b1; e_din = img[i];
        @(negedge clk);
      end
      e_en = 1'b0;
      chk("R9 image crc", e_crc, crc_of(img, 120));
    end

    // directed frames
    frame_check(6'd0, 32'h0, 0);
    frame_check(6'h3F, 32'hFFFF_FFFF, 0);
    frame_check(6'd17, 32'h0000_0200, 1);
    frame_check(6'd9, 32'hDEAD_BEEF, 2);
    frame_check(6'd24, 32'h1234_5678, 3);

    // R7: hold while not ready, frame during pending is dropped
    cmd_ready = 1'b0;
    frame_check(6'd5, 32'hCAFE_0001, 0);
    send_bits(mk(6'd6, 32'h0BAD_0002, 0));
    @(negedge clk) cmd_line = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 held valid", cmd_valid, 1);
    chk("R7 held index", cmd_index, 6'd5);
    chk("R7 held arg", cmd_arg, 32'hCAFE_0001);
    chk("R7 no err", cmd_crc_err, 0);
    cmd_ready = 1'b1;
    @(negedge clk);
    chk("R7 released", cmd_valid, 0);
    repeat (5) begin
      @(negedge clk);
      chk("R7 dropped frame", {cmd_valid, cmd_crc_err}, 0);
    end

    // R8: back to back frames
    begin
      logic [95:0] pair = {mk(6'd12, 32'h1111_2222, 0), mk(6'd13, 32'h3333_4444, 0)};
      for (int j = 95; j >= 0; j--) begin
        @(negedge clk);
        if (j == 47) begin
          chk("R8 first valid", cmd_valid, 1);
          chk("R8 first arg", cmd_arg, 32'h1111_2222);
        end
        cmd_line = pair[j];
      end
      @(negedge clk) cmd_line = 1'b1;
      chk("R8 second valid", cmd_valid, 1);
      chk("R8 second index", cmd_index, 6'd13);
      chk("R8 second arg", cmd_arg, 32'h3333_4444);
    end

    // random frames
    for (int n = 0; n < 60; n++) begin
      int kind = ($urandom_range(3, 0) == 0) ? int'($urandom_range(3, 1)) : 0;
      repeat ($urandom_range(3, 0)) @(negedge clk);
      frame_check($urandom_range(63, 0), $urandom, kind);
    end

    report();
  end
endmodule